// File: doc/BRIEF.md
# Ring Rogue Packet Remover

A node on a unidirectional packet ring passes every header it receives through this block on its way to the transmit side. Any packet whose originator field matches the local node ID has completed its trip around the ring, and the block takes it out of the stream. The node can also hold one or both of two independent "rogue master" roles.

For each role it holds, the block sets that role's marker bit on every foreign packet that goes by. A foreign packet that arrives with that marker already set has passed this master once before. Its originator therefore failed to take it off the ring, so the block discards it as rogue.

Each rogue removal sets a sticky fault flag, which software clears by writing 1. The flag drives an interrupt line when enabled. A saturating counter keeps a tally of rogue removals. All results are registered and appear one clock after the header is presented. Payload words do not pass through this block.

Top module: `ring_rogue_filter`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid`, `drop_own`, `drop_rogue`, `fault`, `irq` and `rogue_count` are all 0.
- R2: A valid header whose originator field (bits `NODE_W-1:0`) equals `local_id` gives `drop_own`=1 and `out_valid`=0 on the next cycle, whatever its marker bits are. It is never counted as rogue.
- R3: For a foreign header and an enabled role k (`role_en[k]`=1) whose marker bit (header bit `NODE_W+k`) is 0, the header is forwarded on the next cycle with that bit set and every other bit unchanged.
- R4: A foreign header that has marker bit k set, for any enabled role k, gives `drop_rogue`=1 and `out_valid`=0 on the next cycle.
- R5: With `role_en`=0, every foreign header is forwarded unchanged on the next cycle.
- R6: A role that is disabled neither tests nor changes its marker bit. A marker set for the other role passes through untouched and does not cause removal.
- R7: `fault` goes to 1 on the cycle after a rogue removal and stays there until `fault_clr` is sampled high. If a clear and a new rogue removal fall in the same cycle, the flag stays set.
- R8: `irq` equals the fault flag ANDed with `irq_en`, both registered in the same cycle.
- R9: `rogue_count` goes up by one for each rogue removal and holds at its maximum value, 2^`CNT_W`-1.
- R10: At most one of `out_valid`, `drop_own`, `drop_rogue` is high in any cycle. All three are 0 on the cycle after `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| local_id | input | NODE_W | ID of this node |
| role_en | input | 2 | Bit k enables rogue master role k |
| in_valid | input | 1 | Header present on `in_hdr` |
| in_hdr | input | HDR_W | Incoming header: originator in low bits, then two marker bits |
| irq_en | input | 1 | Enables the interrupt from the fault flag |
| fault_clr | input | 1 | Write-1-to-clear pulse for the fault flag |
| out_valid | output | 1 | Forwarded header present on `out_hdr` |
| out_hdr | output | HDR_W | Forwarded header with marker bits updated |
| drop_own | output | 1 | Pulse: a returning own packet was removed |
| drop_rogue | output | 1 | Pulse: a rogue packet was removed |
| fault | output | 1 | Sticky rogue fault flag |
| irq | output | 1 | Interrupt request |
| rogue_count | output | CNT_W | Saturating count of rogue removals |

## Verification
The bench runs the cross product of two local IDs, all four role settings, every originator value, all four marker combinations and several user-bit patterns. This sweep separates own-packet removal from rogue removal. It shows that forwarding with a single enabled role sets only that role's bit, and that a marker belonging to a disabled role causes neither removal nor change. Fault clears come at a fixed spacing, so some land on the same cycle as a new rogue hit and test set-over-clear priority. The rogue total passes the counter maximum, which tests saturation. Idle cycles placed between headers confirm that no output fires without input.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int unsigned RRF_ROLES = 2;

  typedef enum logic [1:0] {
    RRF_IDLE       = 2'd0,
    RRF_FWD        = 2'd1,
    RRF_KILL_OWN   = 2'd2,
    RRF_KILL_ROGUE = 2'd3
  } rrf_act_e;
endpackage

// File: rtl/rrf_classify.sv
module rrf_classify
  import rrf_pkg::*;
#(
  parameter int unsigned NODE_W = 8,
  parameter int unsigned HDR_W  = 16
) (
  input  logic                 in_valid,
  input  logic [HDR_W-1:0]     hdr,
  input  logic [NODE_W-1:0]    local_id,
  input  logic [RRF_ROLES-1:0] role_en,
  output rrf_act_e             act,
  output logic [HDR_W-1:0]     hdr_fwd
);
  localparam int unsigned MARK_LO = NODE_W;

  logic [RRF_ROLES-1:0] mark;
  logic [RRF_ROLES-1:0] hit;
  logic [RRF_ROLES-1:0] mark_new;
  logic                 is_own;

  assign mark   = hdr[MARK_LO +: RRF_ROLES];
  assign is_own = (hdr[NODE_W-1:0] == local_id);

  // one tester/marker per role; a disabled role leaves its bit alone
  generate
    for (genvar k = 0; k < RRF_ROLES; k++) begin : g_role
      assign hit[k]      = role_en[k] & mark[k];
      assign mark_new[k] = mark[k] | role_en[k];
    end
  endgenerate

  always_comb begin
    hdr_fwd                         = hdr;
    hdr_fwd[MARK_LO +: RRF_ROLES]   = mark_new;
    if (!in_valid)      act = RRF_IDLE;
    else if (is_own)    act = RRF_KILL_OWN;
    else if (|hit)      act = RRF_KILL_ROGUE;
    else                act = RRF_FWD;
  end
endmodule

// File: rtl/rrf_fault.sv
module rrf_fault #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rogue_hit,
  input  logic             fault_clr,
  input  logic             irq_en,
  output logic             fault,
  output logic             irq,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             fault_q;
  logic             irq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fault_nxt;

  // a new hit wins over a clear in the same cycle
  assign fault_nxt = (fault_q & ~fault_clr) | rogue_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
      irq_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      fault_q <= fault_nxt;
      irq_q   <= fault_nxt & irq_en;
      if (rogue_hit && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fault = fault_q;
  assign irq   = irq_q;
  assign count = cnt_q;

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !fault_clr) |=> fault_q);
  a_r7_set: assert property (@(posedge clk) disable iff (rst)
    rogue_hit |=> fault_q);
  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  a_r9_step: assert property (@(posedge clk) disable iff (rst)
    (rogue_hit && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/ring_rogue_filter.sv
module ring_rogue_filter
  import rrf_pkg::*;
#(
  parameter int unsigned NODE_W = 8,
  parameter int unsigned HDR_W  = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NODE_W-1:0] local_id,
  input  logic [1:0]        role_en,
  input  logic              in_valid,
  input  logic [HDR_W-1:0]  in_hdr,
  input  logic              irq_en,
  input  logic              fault_clr,
  output logic              out_valid,
  output logic [HDR_W-1:0]  out_hdr,
  output logic              drop_own,
  output logic              drop_rogue,
  output logic              fault,
  output logic              irq,
  output logic [CNT_W-1:0]  rogue_count
);
  rrf_act_e         act;
  logic [HDR_W-1:0] hdr_fwd;
  logic             ov_q, own_q, rog_q;
  logic [HDR_W-1:0] hdr_q;

  rrf_classify #(.NODE_W(NODE_W), .HDR_W(HDR_W)) u_cls (
    .in_valid (in_valid),
    .hdr      (in_hdr),
    .local_id (local_id),
    .role_en  (role_en),
    .act      (act),
    .hdr_fwd  (hdr_fwd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q  <= 1'b0;
      own_q <= 1'b0;
      rog_q <= 1'b0;
      hdr_q <= '0;
    end else begin
      ov_q  <= (act == RRF_FWD);
      own_q <= (act == RRF_KILL_OWN);
      rog_q <= (act == RRF_KILL_ROGUE);
      if (act == RRF_FWD) hdr_q <= hdr_fwd;
    end
  end

  rrf_fault #(.CNT_W(CNT_W)) u_flt (
    .clk       (clk),
    .rst       (rst),
    .rogue_hit (act == RRF_KILL_ROGUE),
    .fault_clr (fault_clr),
    .irq_en    (irq_en),
    .fault     (fault),
    .irq       (irq),
    .count     (rogue_count)
  );

  assign out_valid  = ov_q;
  assign out_hdr    = hdr_q;
  assign drop_own   = own_q;
  assign drop_rogue = rog_q;

  a_r2_own_removed: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_hdr[NODE_W-1:0] == local_id) |=> (drop_own && !out_valid && !drop_rogue));
  a_r4_rogue_removed: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_hdr[NODE_W-1:0] != local_id && |(role_en & in_hdr[NODE_W +: 2]))
      |=> (drop_rogue && !out_valid));
  a_r3_marks_set: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rst) |=> (!out_valid || ((out_hdr[NODE_W +: 2] & $past(role_en)) == $past(role_en))));
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, drop_own, drop_rogue}));
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(out_valid || drop_own || drop_rogue));
endmodule

// File: tb/ring_rogue_filter_tb.sv
module ring_rogue_filter_tb;
  localparam int NODE_W = 4;
  localparam int HDR_W  = 8;
  localparam int CNT_W  = 4;
  localparam int CMAX   = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NODE_W-1:0] local_id = '0;
  logic [1:0]        role_en = '0;
  logic              in_valid = 1'b0;
  logic [HDR_W-1:0]  in_hdr = '0;
  logic              irq_en = 1'b0;
  logic              fault_clr = 1'b0;
  logic              out_valid, drop_own, drop_rogue, fault, irq;
  logic [HDR_W-1:0]  out_hdr;
  logic [CNT_W-1:0]  rogue_count;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ring_rogue_filter #(.NODE_W(NODE_W), .HDR_W(HDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .local_id(local_id), .role_en(role_en),
    .in_valid(in_valid), .in_hdr(in_hdr), .irq_en(irq_en), .fault_clr(fault_clr),
    .out_valid(out_valid), .out_hdr(out_hdr), .drop_own(drop_own),
    .drop_rogue(drop_rogue), .fault(fault), .irq(irq), .rogue_count(rogue_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 outputs after reset",
        {out_valid, drop_own, drop_rogue, fault, irq, rogue_count}, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lids[2];
    int n;
    bit fm;
    int cm;
    lids[0] = 5;
    lids[1] = 10;
    n = 0;
    for (int li = 0; li < 2; li++) begin
      local_id = lids[li][NODE_W-1:0];
      do_reset();
      fm = 1'b0;
      cm = 0;
      for (int role = 0; role < 4; role++) begin
        for (int org = 0; org < 16; org++) begin
          for (int mk = 0; mk < 4; mk++) begin
            for (int ub = 0; ub < 4; ub++) begin
              bit own, rog, clr, ie;
              int exp_hdr;
              string tag;
              own = (org == lids[li]);
              rog = !own && ((role & mk) != 0);
              clr = (n % 5) == 0;
              ie  = ub[0];
              exp_hdr = ub * 64 + (mk | role) * 16 + org;
              if (own) tag = "R2";
              else if (rog) tag = "R4";
              else if (role == 0) tag = "R5";
              else if ((mk & ~role & 3) != 0) tag = "R6";
              else tag = "R3";
              @(negedge clk);
              role_en   = role[1:0];
              in_valid  = 1'b1;
              in_hdr    = HDR_W'(ub * 64 + mk * 16 + org);
              fault_clr = clr;
              irq_en    = ie;
              @(negedge clk);
              in_valid  = 1'b0;
              fault_clr = 1'b0;
              fm = (fm & !clr) | rog;
              if (rog && cm < CMAX) cm++;
              chk({tag, " path flags"}, {out_valid, drop_own, drop_rogue},
                  {!own && !rog, own, rog});
              if (!own && !rog) chk({tag, " forwarded header"}, out_hdr, exp_hdr);
              chk("R7 fault flag", fault, fm);
              chk("R8 irq", irq, fm & ie);
              chk("R9 rogue count", rogue_count, cm);
              n++;
              if ((n % 37) == 0) begin
                @(negedge clk);
                chk("R10 idle no output", {out_valid, drop_own, drop_rogue}, 0);
              end
            end
          end
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule